// File: doc/BRIEF.md
# Scan-Testable Rotating Grant Controller

This block is a three-state round-robin grant controller. Each clock in which the advance input is high moves the controller one step around a fixed ring of three states, and the grant output is high in exactly one of them. The state is held in two bits. Of the four possible bit patterns, one is never entered in normal operation. If that pattern ever appears, the next-state logic sends the controller back to its idle state.

Both state flops are mux-D scan cells joined into a single serial chain. With scan enable high, the chain shifts one bit per clock. A tester can therefore place any 2-bit pattern in the register, including the unused one. It then drops scan enable for one capture clock, so the next-state logic acts on that pattern and the current advance input. Finally it shifts the result out. An observe-point output shows the two state bits directly, so a test can read the state without unloading the chain.

Top module: `rotgrant_scan_fsm`

## Requirements
- R1: A synchronous active-high reset, sampled at the rising clock edge, loads the state with idle (code 00), which drives grant low and the observe point to 00.
- R2: With scan enable low and advance high, the state steps from 00 to 01, from 01 to 10, and from 10 back to 00 at each clock.
- R3: With scan enable low and advance low, a legal state (00, 01 or 10) keeps its value.
- R4: With scan enable low, code 11 becomes 00 at the next clock, whatever the value of advance.
- R5: Grant is high exactly while the state holds code 10, and low for 00, 01 and 11.
- R6: With scan enable high, state bit 0 loads scan_in and state bit 1 loads the old bit 0 at each clock. scan_out always shows bit 1, so two shift clocks replace the whole state.
- R7: A single clock with scan enable low, following a scan load, applies the next-state function of R2 to R4 to the loaded code and the advance input.
- R8: The observe point shows {state bit 1, state bit 0} at all times, including while the chain is shifting.
- R9: Reset takes priority over scan enable: when both are high at an edge, the state still becomes 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything is updated on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| adv | input | 1 | Advance request for the grant rotation |
| scan_en | input | 1 | Selects shifting of the chain instead of the next-state logic |
| scan_in | input | 1 | Serial input feeding state bit 0 |
| scan_out | output | 1 | Serial output, equal to state bit 1 |
| grant | output | 1 | High while the state is code 10 |
| state_obs | output | 2 | Observe point carrying the two state bits |

## Verification
The bench loads code 11 through the chain and captures with advance at 0 and at 1. A design missing the recovery branch would instead hold 11 or step to some other code, and the mismatch shows up on the observe point and again on the serial unload. The bench covers all eight combinations of loaded code and advance value. This catches a capture that wrongly holds, skips a state, or raises grant in the wrong state. It also checks the shift direction bit by bit and asserts reset together with scan enable. A chain wired in reverse order, or a reset that loses to the scan mux, would leave the state or scan_out at the wrong value.

// File: rtl/rg_pkg.sv
package rg_pkg;
  localparam int STATE_W = 2;
  localparam logic [STATE_W-1:0] ST_IDLE = 2'b00;
  localparam logic [STATE_W-1:0] ST_MID  = 2'b01;
  localparam logic [STATE_W-1:0] ST_GNT  = 2'b10;
  localparam logic [STATE_W-1:0] ST_BAD  = 2'b11;
endpackage

// File: rtl/rg_next_state.sv
module rg_next_state
  import rg_pkg::*;
(
  input  logic [STATE_W-1:0] cur,
  input  logic               adv,
  output logic [STATE_W-1:0] nxt
);
  always_comb begin
    nxt = cur;
    case (cur)
      ST_IDLE: nxt = adv ? ST_MID  : ST_IDLE;
      ST_MID:  nxt = adv ? ST_GNT  : ST_MID;
      ST_GNT:  nxt = adv ? ST_IDLE : ST_GNT;
      default: nxt = ST_IDLE;  // recovery from the unused code
    endcase
  end
endmodule

// File: rtl/rg_scan_cell.sv
module rg_scan_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic se,
  input  logic si,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (se) q <= si;
    else         q <= d;
  end
endmodule

// File: rtl/rg_decode.sv
module rg_decode
  import rg_pkg::*;
(
  input  logic [STATE_W-1:0] state,
  output logic               grant,
  output logic [STATE_W-1:0] obs
);
  assign grant = (state == ST_GNT);
  assign obs   = state;
endmodule

// File: rtl/rotgrant_scan_fsm.sv
module rotgrant_scan_fsm
  import rg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  input  logic               scan_en,
  input  logic               scan_in,
  output logic               scan_out,
  output logic               grant,
  output logic [STATE_W-1:0] state_obs
);
  localparam int LAST = STATE_W - 1;

  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_d;

  rg_next_state u_next (.cur(state_q), .adv(adv), .nxt(state_d));

  genvar gi;
  generate
    for (gi = 0; gi < STATE_W; gi++) begin : g_chain
      logic link_in;
      if (gi == 0) begin : g_head
        assign link_in = scan_in;
      end else begin : g_body
        assign link_in = state_q[gi-1];
      end
      rg_scan_cell #(.RST_VAL(ST_IDLE[gi])) u_cell (
        .clk(clk), .rst(rst), .se(scan_en), .si(link_in),
        .d(state_d[gi]), .q(state_q[gi])
      );
    end
  endgenerate

  assign scan_out = state_q[LAST];

  rg_decode u_dec (.state(state_q), .grant(grant), .obs(state_obs));

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> state_obs == ST_IDLE); // R1
  AST_RESET_WINS: assert property (@(posedge clk) (rst && scan_en) |=> !grant); // R9
  AST_STEP_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!scan_en && adv && state_obs == ST_IDLE) |=> state_obs == ST_MID); // R2
  AST_HOLD_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (!scan_en && !adv && state_obs != ST_BAD) |=> $stable(state_obs)); // R3
  AST_RECOVER: assert property (@(posedge clk) disable iff (rst)
    (!scan_en && state_obs == ST_BAD) |=> state_obs == ST_IDLE); // R4
  AST_GRANT_NEXT: assert property (@(posedge clk) disable iff (rst)
    (!scan_en && adv && state_obs == ST_MID) |=> grant); // R5
  AST_SHIFT_HEAD: assert property (@(posedge clk) disable iff (rst)
    scan_en |=> state_obs[0] == $past(scan_in)); // R6
  AST_SHIFT_TAIL: assert property (@(posedge clk) disable iff (rst)
    scan_en |=> scan_out == $past(state_obs[0])); // R6
endmodule

// File: tb/test_rotgrant_scan_fsm.sv
`timescale 1ns/1ps
module test_rotgrant_scan_fsm;
  logic clk = 1'b0;
  logic rst, adv, scan_en, scan_in;
  logic scan_out, grant;
  logic [1:0] state_obs;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rotgrant_scan_fsm i_rotgrant_scan_fsm (
    .clk(clk), .rst(rst), .adv(adv), .scan_en(scan_en), .scan_in(scan_in),
    .scan_out(scan_out), .grant(grant), .state_obs(state_obs)
  );

  function automatic logic [1:0] ref_next(input logic [1:0] s, input logic a);
    if (s == 2'b11) return 2'b00;
    if (!a) return s;
    return (s == 2'b10) ? 2'b00 : s + 2'b01;
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    scan_en = 1'b1; scan_in = b; tick();
  endtask

  task automatic load(input logic [1:0] s);
    shift_bit(s[1]);
    check("R6 first bit at bit0", {3'b0, state_obs[0]}, {3'b0, s[1]});
    shift_bit(s[0]);
    check("R8 observe after load", {2'b0, state_obs}, {2'b0, s});
    check("R6 scan_out after load", {3'b0, scan_out}, {3'b0, s[1]});
  endtask

  task automatic capture_and_check(input logic [1:0] s, input logic a);
    logic [1:0] e;
    e = ref_next(s, a);
    load(s);
    scan_en = 1'b0; adv = a; tick();
    if (s == 2'b11) check("R4 recovery capture", {2'b0, state_obs}, {2'b0, e});
    else check("R7 capture next state", {2'b0, state_obs}, {2'b0, e});
    check("R5 grant after capture", {3'b0, grant}, {3'b0, e == 2'b10});
    check("R6 unload bit1", {3'b0, scan_out}, {3'b0, e[1]});
    shift_bit(1'b0);
    check("R6 unload bit0", {3'b0, scan_out}, {3'b0, e[0]});
  endtask

  initial begin
    logic [1:0] model;
    void'($urandom(32'd1234));
    rst = 1'b1; adv = 1'b0; scan_en = 1'b0; scan_in = 1'b0;
    @(negedge clk); tick();
    check("R1 reset state", {2'b0, state_obs}, 4'h0);
    check("R1 reset grant", {3'b0, grant}, 4'h0);
    rst = 1'b0;

    // all eight capture combinations, recovery code included
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 2; a++)
        capture_and_check(s[1:0], a[0]);

    // reset beats scan enable
    load(2'b10);
    rst = 1'b1; scan_en = 1'b1; scan_in = 1'b1; tick();
    check("R9 reset over scan", {2'b0, state_obs}, 4'h0);
    rst = 1'b0; scan_en = 1'b0; adv = 1'b0; tick();

    // functional random run
    model = 2'b00;
    for (int i = 0; i < 200; i++) begin
      adv = 1'($urandom_range(0, 1));
      model = ref_next(model, adv);
      tick();
      check(adv ? "R2 rotation" : "R3 hold", {2'b0, state_obs}, {2'b0, model});
      check("R5 grant decode", {3'b0, grant}, {3'b0, model == 2'b10});
    end

    // random scan loads and captures
    for (int i = 0; i < 40; i++)
      capture_and_check(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));

    // observe point while shifting a pattern through
    scan_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      logic b, prev0;
      b = 1'($urandom_range(0, 1));
      prev0 = state_obs[0];
      scan_in = b; tick();
      check("R8 observe during shift", {2'b0, state_obs}, {2'b0, prev0, b});
    end
    scan_en = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule